// File: doc/BRIEF.md
# Run-time selectable third-order comb-integrator decimator

This block turns a one-bit oversampled stream, such as the output of a sigma-delta modulator, into a lower-rate signed sample. It runs a three-stage integrator cascade at the input rate. At the decimated rate it runs a three-stage differentiator (comb) cascade, which gives the transfer function ((1 - z^-N)/(1 - z^-1))^3. A companion clock-enable marks every cycle that carries a new input bit, so the block can share a fast system clock with slower modulator timing.

A two-bit select picks the decimation ratio N out of four powers of two, from 32 up to 256. It can be changed while the block runs. Each change flushes the filter history. The block then stays silent until the new ratio has produced fully settled results. Every result is scaled to a 15-bit two's-complement word and presented with a one-clock strobe. The word holds its value until the next strobe.

Top module: `sinc3_decim`

## Requirements
- R1: A `bit_in` of 1 counts as +1 and a 0 counts as -1. A settled stream of all zeros gives `smp_out` = -16384 at every ratio.
- R2: `rate_sel` values 0, 1, 2 and 3 select N = 32, 64, 128 and 256. Once output has started, consecutive strobes are exactly N enabled input bits apart.
- R3: `smp_valid` is high for exactly one clock. It rises in the clock that follows the edge capturing the last enabled bit of a period, and the new word appears on `smp_out` in that same clock.
- R4: When `bit_en` is low, `bit_in` has no effect on the filter, on the timing or on any result.
- R5: The comb result is shifted arithmetically right by 3*log2(N) - 14. A stream whose density of ones is exactly 3/4 (repeating 1,1,1,0) gives 8192 at every ratio.
- R6: A strictly alternating stream 1,0,1,0,... gives 0 at every ratio.
- R7: A scaled result above 16383 saturates to 16383. A settled stream of all ones gives 16383 at every ratio.
- R8: Reset and any change of `rate_sel` clear all filter state and restart the period count. The first strobe comes after exactly 4*N enabled bits, so three full periods are suppressed.
- R9: Out of reset, `smp_valid` is 0 and `smp_out` is 0.
- R10: `smp_out` keeps its value in every clock in which `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | High in cycles that carry a new input bit |
| bit_in | input | 1 | One-bit modulator stream |
| rate_sel | input | 2 | Decimation ratio select (0:32, 1:64, 2:128, 3:256) |
| smp_out | output | 15 | Decimated two's-complement sample |
| smp_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
Each result falls due in the clock right after the edge that captures the 4N-th enabled bit following a clear. Each later result falls due exactly N enabled bits after the one before. There is one register from that edge to the output. The bench drives inputs on falling edges. It checks the outputs on the following falling edge before it drives again. At that moment the number of bits handed over equals the number already captured, so the bench compares its own bit count with 4N or (4+k)N whenever the strobe is seen. The stimulus patterns are chosen so that every settled result is exact and independent of phase. This lets even the first released word be compared against a value computed from the requirements. Runs with idle gaps feed inverted bits during the gaps, so any leakage would move both the timing and the value.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
    localparam int STAGES     = 3;
    localparam int MIN_LOG2N  = 5;
    localparam int MAX_LOG2N  = 8;
    localparam int OUT_W      = 15;
    localparam int RATE_W     = 2;
    localparam int ACC_W      = STAGES * MAX_LOG2N + 2;
    localparam int PH_W       = MAX_LOG2N;
    localparam int WARM_TICKS = STAGES;
    localparam int WARM_W     = $clog2(WARM_TICKS + 1);
    localparam int SH_W       = $clog2(STAGES * MAX_LOG2N);

    function automatic int unsigned rate_log2(input logic [RATE_W-1:0] r);
        return MIN_LOG2N + int'(r);
    endfunction

    function automatic logic [PH_W-1:0] phase_last(input logic [RATE_W-1:0] r);
        return {PH_W{1'b1}} >> (MAX_LOG2N - rate_log2(r));
    endfunction

    function automatic logic [SH_W-1:0] out_shift(input logic [RATE_W-1:0] r);
        return SH_W'(STAGES * rate_log2(r) - (OUT_W - 1));
    endfunction
endpackage

// File: rtl/sinc3_ctrl.sv
`timescale 1ns/1ps
module sinc3_ctrl
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [RATE_W-1:0] rate_q,
    output logic              clear,
    output logic              step,
    output logic              tick,
    output logic              emit
);
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [PH_W-1:0]   phase;
        logic [WARM_W-1:0] warm;
    } ctrl_t;

    ctrl_t s_q, s_d;
    logic  at_last;
    logic  warm_full;

    always_comb begin
        s_d       = s_q;
        clear     = (rate_sel != s_q.rate);
        step      = bit_en && !clear;
        at_last   = (s_q.phase == phase_last(s_q.rate));
        warm_full = (s_q.warm == WARM_W'(WARM_TICKS));
        tick      = step && at_last;
        emit      = tick && warm_full;
        if (clear) begin
            s_d.rate  = rate_sel;
            s_d.phase = '0;
            s_d.warm  = '0;
        end else if (step) begin
            if (at_last) begin
                s_d.phase = '0;
                if (!warm_full) begin
                    s_d.warm = s_q.warm + WARM_W'(1);
                end
            end else begin
                s_d.phase = s_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rate_q = s_q.rate;

    // R8: a ratio change restarts both the period and the settling count
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.phase == '0) && (s_q.warm == '0) && (s_q.rate == $past(rate_sel)));

    // R2: a period boundary returns the phase count to zero
    p_period_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (s_q.phase == '0));

    // R4: without an enabled bit the timing state does not move
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !clear) |=> $stable(s_q));
endmodule

// File: rtl/sinc3_integ.sv
`timescale 1ns/1ps
module sinc3_integ
    import sinc3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic             bit_in,
    output logic [ACC_W-1:0] acc_nxt
);
    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t           s_q, s_d;
    logic [ACC_W-1:0] x_in;
    logic [ACC_W-1:0] sum [STAGES];

    assign x_in = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign sum[g] = s_q.acc[g] + x_in;
        end else begin : g_next
            assign sum[g] = s_q.acc[g] + s_q.acc[g-1];
        end
    end

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.acc = '0;
        end else if (step) begin
            for (int k = 0; k < STAGES; k++) begin
                s_d.acc[k] = sum[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_nxt = sum[STAGES-1];

    // R4: integrators ignore the input when no bit is enabled
    p_integ_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(s_q.acc));

    // R8: a clear leaves every integrator at zero
    p_integ_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.acc == '0));
endmodule

// File: rtl/sinc3_comb.sv
`timescale 1ns/1ps
module sinc3_comb
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    input  logic              emit,
    input  logic [RATE_W-1:0] rate,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [OUT_W-1:0]  smp,
    output logic              valid
);
    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] dly;
        logic [OUT_W-1:0]             smp;
        logic                         vld;
    } comb_t;

    comb_t                   s_q, s_d;
    logic [ACC_W-1:0]        stage_v [STAGES+1];
    logic signed [ACC_W-1:0] shifted;
    logic [ACC_W-OUT_W:0]    head;
    logic                    fits;
    logic [OUT_W-1:0]        scaled;

    assign stage_v[0] = acc_in;
    for (genvar g = 0; g < STAGES; g++) begin : g_diff
        assign stage_v[g+1] = stage_v[g] - s_q.dly[g];
    end

    always_comb begin
        shifted = $signed(stage_v[STAGES]) >>> out_shift(rate);
        head    = shifted[ACC_W-1:OUT_W-1];
        fits    = (&head) || !(|head);
        if (fits) begin
            scaled = shifted[OUT_W-1:0];
        end else if (shifted[ACC_W-1]) begin
            scaled = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            scaled = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.vld = emit;
        if (emit) begin
            s_d.smp = scaled;
        end
        if (clear) begin
            s_d.dly = '0;
        end else if (tick) begin
            for (int k = 0; k < STAGES; k++) begin
                s_d.dly[k] = stage_v[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign smp   = s_q.smp;
    assign valid = s_q.vld;

    // R3: the strobe never lasts two clocks
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R10: the word only moves together with the strobe
    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(smp));

    // R8: the comb history is empty after a clear
    p_comb_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.dly == '0) && !valid);
endmodule

// File: rtl/sinc3_decim.sv
`timescale 1ns/1ps
module sinc3_decim
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [OUT_W-1:0]  smp_out,
    output logic              smp_valid
);
    logic [RATE_W-1:0] rate_q;
    logic              clear;
    logic              step;
    logic              tick;
    logic              emit;
    logic [ACC_W-1:0]  acc_nxt;

    sinc3_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rate_sel (rate_sel),
        .rate_q   (rate_q),
        .clear    (clear),
        .step     (step),
        .tick     (tick),
        .emit     (emit)
    );

    sinc3_integ u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .clear   (clear),
        .bit_in  (bit_in),
        .acc_nxt (acc_nxt)
    );

    sinc3_comb u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .tick   (tick),
        .emit   (emit),
        .rate   (rate_q),
        .acc_in (acc_nxt),
        .smp    (smp_out),
        .valid  (smp_valid)
    );
endmodule

// File: tb/sim_sinc3_decim.sv
`timescale 1ns/1ps
module sim_sinc3_decim;
    logic        clk;
    logic        rst_n;
    logic        bit_en;
    logic        bit_in;
    logic [1:0]  rate_sel;
    logic [14:0] smp_out;
    logic        smp_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    localparam int K_ONES  = 0;
    localparam int K_ZEROS = 1;
    localparam int K_ALT   = 2;
    localparam int K_3Q    = 3;

    sinc3_decim u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .rate_sel  (rate_sel),
        .smp_out   (smp_out),
        .smp_valid (smp_valid)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pat(input int kind, input int idx);
        case (kind)
            K_ONES:  return 1'b1;
            K_ZEROS: return 1'b0;
            K_ALT:   return (idx % 2 == 0);
            default: return (idx % 4 != 3);
        endcase
    endfunction

    function automatic int expect_val(input int kind);
        case (kind)
            K_ONES:  return 16383;
            K_ZEROS: return -16384;
            K_ALT:   return 0;
            default: return 8192;
        endcase
    endfunction

    task automatic set_rate(input int r);
        @(negedge clk);
        bit_en   = 1'b0;
        rate_sel = 2'(r);
        @(negedge clk);
        @(negedge clk);
    endtask

    // R9: state straight out of reset
    task automatic t_reset_state();
        check(smp_valid == 1'b0, "R9 valid", int'(smp_valid), 0);
        check(smp_out == 15'd0, "R9 sample", int'(smp_out), 0);
    endtask

    // Feed a pattern and check timing and value of each strobe
    task automatic t_run(input int r, input int kind, input int nout, input bit gaps, input string vreq);
        int  n    = 32 << r;
        int  sent = 0;
        int  got  = 0;
        int  cyc  = 0;
        int  idx  = 0;
        bit  prev = 0;
        bit  hold_bad = 0;
        logic [14:0] held = smp_out;
        set_rate(r);
        while (got < nout && cyc < 20000) begin
            @(negedge clk);
            if (smp_valid) begin
                if (got == 0)
                    check(sent == 4 * n && !prev, "R8 first strobe bit count", sent, 4 * n);
                else
                    check(sent == (4 + got) * n && !prev, "R2/R3 strobe spacing", sent, (4 + got) * n);
                check($signed(smp_out) == expect_val(kind), vreq, int'($signed(smp_out)), expect_val(kind));
                held = smp_out;
                got++;
            end else if (smp_out !== held) begin
                hold_bad = 1;
            end
            prev = smp_valid;
            if (gaps && (cyc % 3 == 1)) begin
                bit_en = 1'b0;
                bit_in = ~pat(kind, idx);
            end else begin
                bit_en = 1'b1;
                bit_in = pat(kind, idx);
                idx++;
                sent++;
            end
            cyc++;
        end
        @(negedge clk);
        bit_en = 1'b0;
        check(got == nout, "R2 strobes delivered", got, nout);
        check(!hold_bad, "R10 word held between strobes", int'(hold_bad), 0);
    endtask

    // R8: a partial stream shorter than the settling span yields no strobe
    task automatic t_partial(input int r, input int nbits);
        int seen = 0;
        set_rate(r);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (smp_valid) seen++;
            bit_en = 1'b1;
            bit_in = pat(K_ONES, i);
        end
        @(negedge clk);
        if (smp_valid) seen++;
        bit_en = 1'b0;
        check(seen == 0, "R8 no strobe while settling", seen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        bit_en   = 1'b0;
        bit_in   = 1'b0;
        rate_sel = 2'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_run(0, K_ONES,  3, 0, "R7 all ones saturate");
        t_run(1, K_ZEROS, 3, 1, "R1/R4 all zeros with gaps");
        t_run(2, K_ALT,   2, 0, "R6 alternating");
        t_run(3, K_3Q,    2, 0, "R5 three-quarter density");
        t_partial(2, 300);
        t_run(1, K_3Q,    2, 1, "R5/R4 three-quarter after restart");
        t_run(0, K_ZEROS, 2, 0, "R1 all zeros");
        t_run(3, K_ONES,  2, 1, "R7 all ones with gaps");
        t_run(2, K_3Q,    2, 1, "R5 three-quarter");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule